// File: doc/BRIEF.md
# Vector Length Configuration Unit

This unit carries out a set-vector-length operation on a small piece of architectural state. That state has four parts: a maximum vector length, a current vector length, a vertical-first flag and a persist flag. The issuing pipeline hands over the already-decoded operand fields. These are a destination index, a source index, a 7-bit length immediate, three mode flags and a record flag. The unit also receives the source register value and the loop count register value. In the cycle after issue, the unit presents the updated state, a write-back value for the destination register with its enable, and a four-bit condition result.

The new length comes from one of four places: the held length, the source register, the immediate or the count register. The choice depends on the mode flag and on which of the two register indices are zero. The immediate field holds the length minus one, so seven bits cover 1 to 128. Register-sourced values above 127 saturate. Whatever is chosen is then clamped to the maximum length, and either kind of clipping raises an overflow flag. When the record flag is set, the condition result describes the new length, not the destination register.

Both lengths are held one bit wider than the immediate, so that a length of 128 can be stored. Reset is synchronous and active-high.

Top module: `vlcfg_top`

## Requirements
- R1: After synchronous reset, mvl, vl, vfirst, persist, wb_en and cr_we are all zero.
- R2: When issue and ms=1, mvl becomes imm+1, where imm value 0..127 gives 1..128. When ms=0, mvl keeps its value.
- R3: When issue and vs=0, the candidate length is the held vl. It is still clamped to the new mvl, as in R7.
- R4: When issue, vs=1 and ra_idx≠0, the candidate is ra_val. If ra_val is greater than 127 unsigned, the candidate is 127 and overflow is raised.
- R5: When issue, vs=1, ra_idx=0 and rt_idx=0, the candidate is imm+1.
- R6: When issue, vs=1, ra_idx=0 and rt_idx≠0, the candidate is ctr_val. If ctr_val is greater than 127 unsigned, it saturates to 127 with overflow.
- R7: The new vl is the smaller of the candidate and the new mvl. A candidate above the new mvl raises overflow. vl never exceeds mvl.
- R8: In the cycle after an issue with rt_idx≠0, wb_en is 1 and wb_data is the new vl zero-extended to 64 bits. With rt_idx=0, wb_en is 0.
- R9: vfirst takes vf only when ms=1, and keeps its value otherwise. Every issue clears persist.
- R10: After an issue with rc=1, cr_we is 1, cr_eq=(vl==0), cr_gt=(vl≠0), cr_lt=0 and cr_so equals the overflow flag. This holds even when rt_idx=0. After an issue with rc=0, cr_we is 0.
- R11: In a cycle without issue, the state holds and both wb_en and cr_we are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | Operation issued this cycle |
| rt_idx | input | 5 | Destination register index; 0 selects the count register source and suppresses write-back |
| ra_idx | input | 5 | Source register index; nonzero selects ra_val |
| imm | input | 7 | Length immediate, stored as value minus one |
| ms | input | 1 | Load maximum length from the immediate |
| vs | input | 1 | Load the current length from the selected source |
| vf | input | 1 | Vertical-first value, applied only with ms |
| rc | input | 1 | Record flag: write the condition result |
| ra_val | input | 64 | Value of the source register |
| ctr_val | input | 64 | Value of the count register |
| mvl | output | 8 | Held maximum vector length |
| vl | output | 8 | Held current vector length |
| vfirst | output | 1 | Held vertical-first flag |
| persist | output | 1 | Held persist flag |
| wb_en | output | 1 | Destination write-back enable |
| wb_data | output | 64 | Destination write-back value |
| cr_we | output | 1 | Condition result write enable |
| cr_lt | output | 1 | Condition less-than bit |
| cr_gt | output | 1 | Condition greater-than bit |
| cr_eq | output | 1 | Condition equal bit |
| cr_so | output | 1 | Condition summary-overflow bit |

## Verification
The bench builds the unit with its defaults: a 7-bit length field, 64-bit data and 5-bit indices. With these values the immediate can reach both ends of its range. Setting imm=127 on both paths gives a length of 128, which only the widened state can hold. Register and count values with bits above bit 40 set exercise saturation to 127 along the full 64-bit compare. Shrinking the maximum below a held length, and issuing with a zero maximum straight after reset, both cover the clamp path and its overflow report.

// File: rtl/vlcfg_pkg.sv
package vlcfg_pkg;

  typedef enum logic [1:0] {
    SRC_HOLD = 2'd0,
    SRC_REG  = 2'd1,
    SRC_IMM  = 2'd2,
    SRC_CTR  = 2'd3
  } len_src_e;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } cond_t;

endpackage

// File: rtl/vlcfg_sat.sv
// Reduce a wide register value to a length, saturating at the largest
// value the length field can express without the extra top bit.
module vlcfg_sat #(
  parameter int XLEN  = 64,
  parameter int LEN_W = 7
) (
  input  logic [XLEN-1:0]  val_i,
  output logic [LEN_W:0]   len_o,
  output logic             sat_o
);
  localparam int SW = LEN_W + 1;
  localparam logic [SW-1:0] SAT_MAX = SW'((1 << LEN_W) - 1);

  always_comb begin
    sat_o = |val_i[XLEN-1:LEN_W];
    len_o = sat_o ? SAT_MAX : {1'b0, val_i[LEN_W-1:0]};
  end
endmodule

// File: rtl/vlcfg_src_sel.sv
// Picks the candidate length among held value, register, immediate and count.
module vlcfg_src_sel
  import vlcfg_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int LEN_W = 7,
  parameter int IDX_W = 5
) (
  input  logic             vs_i,
  input  logic [IDX_W-1:0] rt_idx_i,
  input  logic [IDX_W-1:0] ra_idx_i,
  input  logic [LEN_W:0]   imm_len_i,
  input  logic [XLEN-1:0]  ra_val_i,
  input  logic [XLEN-1:0]  ctr_val_i,
  input  logic [LEN_W:0]   vl_cur_i,
  output logic [LEN_W:0]   cand_o,
  output logic             sat_o
);
  localparam int NSAT = 2;

  logic [XLEN-1:0] wide_in  [NSAT];
  logic [LEN_W:0]  wide_len [NSAT];
  logic            wide_sat [NSAT];
  len_src_e        sel;

  assign wide_in[0] = ra_val_i;
  assign wide_in[1] = ctr_val_i;

  for (genvar g = 0; g < NSAT; g++) begin : g_sat
    vlcfg_sat #(.XLEN(XLEN), .LEN_W(LEN_W)) u_sat (
      .val_i (wide_in[g]),
      .len_o (wide_len[g]),
      .sat_o (wide_sat[g])
    );
  end

  always_comb begin
    if (!vs_i)                  sel = SRC_HOLD;
    else if (ra_idx_i != '0)    sel = SRC_REG;
    else if (rt_idx_i == '0)    sel = SRC_IMM;
    else                        sel = SRC_CTR;
  end

  always_comb begin
    cand_o = vl_cur_i;
    sat_o  = 1'b0;
    unique case (sel)
      SRC_HOLD: begin cand_o = vl_cur_i;    sat_o = 1'b0;        end
      SRC_REG:  begin cand_o = wide_len[0]; sat_o = wide_sat[0]; end
      SRC_IMM:  begin cand_o = imm_len_i;   sat_o = 1'b0;        end
      SRC_CTR:  begin cand_o = wide_len[1]; sat_o = wide_sat[1]; end
      default:  begin cand_o = vl_cur_i;    sat_o = 1'b0;        end
    endcase
  end
endmodule

// File: rtl/vlcfg_clamp.sv
// Limits the candidate length to the maximum and reports clipping.
module vlcfg_clamp #(
  parameter int LEN_W = 7
) (
  input  logic [LEN_W:0] cand_i,
  input  logic           sat_i,
  input  logic [LEN_W:0] mvl_i,
  output logic [LEN_W:0] vl_o,
  output logic           ovf_o
);
  logic over;

  always_comb begin
    over  = cand_i > mvl_i;
    vl_o  = over ? mvl_i : cand_i;
    ovf_o = over | sat_i;
  end
endmodule

// File: rtl/vlcfg_cond.sv
// Builds the condition result from the new length and the overflow flag.
module vlcfg_cond
  import vlcfg_pkg::*;
#(
  parameter int LEN_W = 7
) (
  input  logic [LEN_W:0] vl_i,
  input  logic           ovf_i,
  output cond_t          cond_o
);
  always_comb begin
    cond_o.lt = 1'b0;
    cond_o.eq = (vl_i == '0);
    cond_o.gt = (vl_i != '0);
    cond_o.so = ovf_i;
  end
endmodule

// File: rtl/vlcfg_top.sv
module vlcfg_top
  import vlcfg_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int LEN_W = 7,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue,
  input  logic [IDX_W-1:0] rt_idx,
  input  logic [IDX_W-1:0] ra_idx,
  input  logic [LEN_W-1:0] imm,
  input  logic             ms,
  input  logic             vs,
  input  logic             vf,
  input  logic             rc,
  input  logic [XLEN-1:0]  ra_val,
  input  logic [XLEN-1:0]  ctr_val,
  output logic [LEN_W:0]   mvl,
  output logic [LEN_W:0]   vl,
  output logic             vfirst,
  output logic             persist,
  output logic             wb_en,
  output logic [XLEN-1:0]  wb_data,
  output logic             cr_we,
  output logic             cr_lt,
  output logic             cr_gt,
  output logic             cr_eq,
  output logic             cr_so
);
  localparam int SW = LEN_W + 1;

  logic [SW-1:0]   mvl_q, vl_q;
  logic            vfirst_q, persist_q;
  logic            wb_en_q, cr_we_q;
  logic [XLEN-1:0] wb_data_q;
  cond_t           cond_q;

  logic [SW-1:0]   imm_len, mvl_nx, cand, vl_nx;
  logic            sat, ovf;
  cond_t           cond_nx;

  assign imm_len = {1'b0, imm} + SW'(1);
  assign mvl_nx  = ms ? imm_len : mvl_q;

  vlcfg_src_sel #(.XLEN(XLEN), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_src (
    .vs_i      (vs),
    .rt_idx_i  (rt_idx),
    .ra_idx_i  (ra_idx),
    .imm_len_i (imm_len),
    .ra_val_i  (ra_val),
    .ctr_val_i (ctr_val),
    .vl_cur_i  (vl_q),
    .cand_o    (cand),
    .sat_o     (sat)
  );

  vlcfg_clamp #(.LEN_W(LEN_W)) u_clamp (
    .cand_i (cand),
    .sat_i  (sat),
    .mvl_i  (mvl_nx),
    .vl_o   (vl_nx),
    .ovf_o  (ovf)
  );

  vlcfg_cond #(.LEN_W(LEN_W)) u_cond (
    .vl_i   (vl_nx),
    .ovf_i  (ovf),
    .cond_o (cond_nx)
  );

  // Architectural state
  always_ff @(posedge clk) begin
    if (rst) begin
      mvl_q     <= '0;
      vl_q      <= '0;
      vfirst_q  <= 1'b0;
      persist_q <= 1'b0;
    end else if (issue) begin
      mvl_q     <= mvl_nx;
      vl_q      <= vl_nx;
      persist_q <= 1'b0;
      if (ms) vfirst_q <= vf;
    end
  end

  // Result pulses
  always_ff @(posedge clk) begin
    if (rst) begin
      wb_en_q   <= 1'b0;
      wb_data_q <= '0;
      cr_we_q   <= 1'b0;
      cond_q    <= '0;
    end else begin
      wb_en_q <= issue && (rt_idx != '0);
      cr_we_q <= issue && rc;
      if (issue) begin
        wb_data_q <= XLEN'(vl_nx);
        cond_q    <= cond_nx;
      end
    end
  end

  assign mvl     = mvl_q;
  assign vl      = vl_q;
  assign vfirst  = vfirst_q;
  assign persist = persist_q;
  assign wb_en   = wb_en_q;
  assign wb_data = wb_data_q;
  assign cr_we   = cr_we_q;
  assign cr_lt   = cond_q.lt;
  assign cr_gt   = cond_q.gt;
  assign cr_eq   = cond_q.eq;
  assign cr_so   = cond_q.so;

  // Checks on the state registers and result pulses
  p_ms_load_r2: assert property (@(posedge clk) disable iff (rst)
    issue && ms |=> mvl_q == SW'($past(imm)) + SW'(1));

  p_ms_keep_r2: assert property (@(posedge clk) disable iff (rst)
    issue && !ms |=> $stable(mvl_q));

  p_vl_bound_r7: assert property (@(posedge clk) disable iff (rst)
    vl_q <= mvl_q);

  p_no_wb_r8: assert property (@(posedge clk) disable iff (rst)
    issue && (rt_idx == '0) |=> !wb_en_q);

  p_wb_value_r8: assert property (@(posedge clk) disable iff (rst)
    wb_en_q |-> wb_data_q == XLEN'(vl_q));

  p_vf_keep_r9: assert property (@(posedge clk) disable iff (rst)
    issue && !ms |=> $stable(vfirst_q));

  p_persist_clr_r9: assert property (@(posedge clk) disable iff (rst)
    issue |=> !persist_q);

  p_cond_shape_r10: assert property (@(posedge clk) disable iff (rst)
    cr_we_q |-> !cond_q.lt && (cond_q.eq != cond_q.gt) && (cond_q.eq == (vl_q == '0)));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !issue |=> $stable(mvl_q) && $stable(vl_q) && !wb_en_q && !cr_we_q);
endmodule

// File: tb/sim_vlcfg_top.sv
`timescale 1ns/1ps
module sim_vlcfg_top;
  localparam int XLEN  = 64;
  localparam int LEN_W = 7;
  localparam int IDX_W = 5;
  localparam int SW    = LEN_W + 1;

  logic clk = 1'b0;
  logic rst;
  logic issue;
  logic [IDX_W-1:0] rt_idx, ra_idx;
  logic [LEN_W-1:0] imm;
  logic ms, vs, vf, rc;
  logic [XLEN-1:0] ra_val, ctr_val;
  logic [SW-1:0] mvl, vl;
  logic vfirst, persist, wb_en, cr_we, cr_lt, cr_gt, cr_eq, cr_so;
  logic [XLEN-1:0] wb_data;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // bench-side model of the state
  int m_mvl = 0, m_vl = 0;
  bit m_vf  = 0;

  always #2.5 clk = ~clk;

  vlcfg_top #(.XLEN(XLEN), .LEN_W(LEN_W), .IDX_W(IDX_W)) u0 (
    .clk, .rst, .issue, .rt_idx, .ra_idx, .imm, .ms, .vs, .vf, .rc,
    .ra_val, .ctr_val, .mvl, .vl, .vfirst, .persist, .wb_en, .wb_data,
    .cr_we, .cr_lt, .cr_gt, .cr_eq, .cr_so
  );

  task automatic chk(input string tag, input string what,
                     input longint unsigned act, input longint unsigned exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    issue = 0; rt_idx = '0; ra_idx = '0; imm = '0;
    ms = 0; vs = 0; vf = 0; rc = 0; ra_val = '0; ctr_val = '0;
  endtask

  // Issue one operation, then check every output against the model.
  task automatic exec(input string tag, input int rt, input int ra,
                      input int im, input bit f_ms, input bit f_vs,
                      input bit f_vf, input bit f_rc,
                      input longint unsigned rav, input longint unsigned ctv);
    int cand, nmvl, nvl;
    bit ov;
    @(negedge clk);
    issue = 1; rt_idx = IDX_W'(rt); ra_idx = IDX_W'(ra); imm = LEN_W'(im);
    ms = f_ms; vs = f_vs; vf = f_vf; rc = f_rc; ra_val = rav; ctr_val = ctv;
    ov = 0;
    if (!f_vs) cand = m_vl;
    else if (ra != 0) begin
      if (rav > 127) begin cand = 127; ov = 1; end else cand = int'(rav);
    end else if (rt == 0) cand = im + 1;
    else begin
      if (ctv > 127) begin cand = 127; ov = 1; end else cand = int'(ctv);
    end
    nmvl = f_ms ? im + 1 : m_mvl;
    if (cand > nmvl) begin nvl = nmvl; ov = 1; end else nvl = cand;
    m_mvl = nmvl; m_vl = nvl;
    if (f_ms) m_vf = f_vf;
    @(negedge clk);
    idle_inputs();
    chk(tag, "mvl", mvl, m_mvl);
    chk(tag, "vl", vl, m_vl);
    chk(tag, "vfirst", vfirst, m_vf);
    chk("R9", "persist", persist, 0);
    chk(tag, "wb_en", wb_en, rt != 0);
    if (rt != 0) chk(tag, "wb_data", wb_data, nvl);
    chk(tag, "cr_we", cr_we, f_rc);
    if (f_rc) begin
      chk(tag, "cr_eq", cr_eq, nvl == 0);
      chk(tag, "cr_gt", cr_gt, nvl != 0);
      chk(tag, "cr_lt", cr_lt, 0);
      chk(tag, "cr_so", cr_so, ov);
    end
  endtask

  task automatic t_reset();
    idle_inputs();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1", "mvl", mvl, 0);
    chk("R1", "vl", vl, 0);
    chk("R1", "vfirst", vfirst, 0);
    chk("R1", "persist", persist, 0);
    chk("R1", "wb_en", wb_en, 0);
    chk("R1", "cr_we", cr_we, 0);
  endtask

  task automatic t_zero_max();
    // length request against a zero maximum: clamped to 0 with overflow
    exec("R7", 0, 0, 3, 0, 1, 0, 1, 0, 0);
    chk("R7", "so_on_zero_max", cr_so, 1);
  endtask

  task automatic t_set_max();
    exec("R2", 0, 0, 7, 1, 0, 1, 1, 0, 0);      // max 8, vfirst 1
    chk("R2", "mvl_is_8", mvl, 8);
  endtask

  task automatic t_imm_src();
    exec("R5", 0, 0, 4, 0, 1, 0, 1, 0, 0);      // 5
    chk("R5", "vl_is_5", vl, 5);
    exec("R7", 0, 0, 20, 0, 1, 0, 1, 0, 0);     // 21 clipped to 8
    chk("R7", "clip_so", cr_so, 1);
  endtask

  task automatic t_reg_src();
    exec("R4", 0, 3, 0, 0, 1, 0, 1, 6, 0);      // 6, no write-back
    chk("R8", "no_wb_rt0", wb_en, 0);
    exec("R4", 9, 3, 127, 1, 1, 1, 1, 64'h1 << 40, 0);  // max 128, sat 127
    chk("R4", "sat_127", vl, 127);
    chk("R4", "sat_so", cr_so, 1);
  endtask

  task automatic t_ctr_src();
    exec("R6", 4, 0, 0, 0, 1, 0, 1, 0, 50);
    chk("R6", "wb_50", wb_data, 50);
    exec("R6", 4, 0, 0, 0, 1, 0, 1, 0, 64'hFFFF_0000_0000_0000);
    chk("R6", "ctr_sat", vl, 127);
    exec("R10", 4, 0, 0, 0, 1, 0, 1, 0, 0);
    chk("R10", "eq_on_zero", cr_eq, 1);
  endtask

  task automatic t_hold_src();
    exec("R6", 2, 0, 0, 0, 1, 0, 0, 0, 50);     // vl 50, rc=0
    chk("R10", "no_cr_rc0", cr_we, 0);
    exec("R3", 0, 0, 9, 1, 0, 0, 1, 0, 0);      // max 10: held 50 clipped
    chk("R3", "held_clip", vl, 10);
    exec("R9", 0, 0, 0, 0, 0, 1, 1, 0, 0);      // vf without ms ignored
    chk("R9", "vf_kept", vfirst, 0);
    exec("R3", 7, 5, 3, 0, 0, 0, 1, 2, 2);      // vs=0: register ignored
    chk("R3", "vs0_wb", wb_data, 10);
  endtask

  task automatic t_full_len();
    exec("R2", 1, 0, 127, 1, 1, 1, 1, 0, 0);    // rt!=0 -> count source 0
    exec("R5", 0, 0, 127, 1, 1, 1, 1, 0, 0);    // 128 / 128
    chk("R5", "vl_128", vl, 128);
    exec("R8", 6, 0, 0, 0, 0, 0, 0, 0, 0);      // read back 128
    chk("R8", "wb_128", wb_data, 128);
  endtask

  task automatic t_idle();
    @(negedge clk);
    ra_val = 64'd5; ctr_val = 64'd9; imm = 7'd1; vs = 1; ms = 1; rt_idx = 5'd3;
    repeat (3) @(negedge clk);
    chk("R11", "mvl_hold", mvl, m_mvl);
    chk("R11", "vl_hold", vl, m_vl);
    chk("R11", "wb_en_idle", wb_en, 0);
    chk("R11", "cr_we_idle", cr_we, 0);
    idle_inputs();
  endtask

  initial begin
    idle_inputs();
    rst = 1;
    t_reset();
    t_zero_max();
    t_set_max();
    t_imm_src();
    t_reg_src();
    t_ctr_src();
    t_hold_src();
    t_full_len();
    t_idle();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule